// File: doc/BRIEF.md
# Receive Bit-Period Checker for a Consumer-Electronics Control Bus

This block watches the single open-drain line of a consumer-electronics control bus while its receiver is switched on. The line passes through a synchronizer and a glitch filter that runs on a slow sampling tick, one system-clock cycle wide and nominally at 32.768 kHz. A start bit arms the block: a low of at least a set number of ticks followed by a release of the line. From then on it measures, in sampling ticks, the time from each data bit's falling edge to the next one.

A period shorter than the trimmed minimum is a short-cycle fault. The block then pulls the line low for a fixed error-signalling time, so that the other devices see the fault. A period longer than the trimmed maximum is a long-cycle fault, and it is reported as soon as the limit is passed. After either fault the partly received frame is dropped and the block hunts for a new start bit. Each fault sets a sticky status flag that software clears by writing one. An interrupt is raised for every flag that is enabled. The trim inputs may be changed only while `busy` is low.

Top module: `cec_period_check`

## Requirements
- R1: After reset, `cecDriveLow`, `busy`, `statMin`, `statMax` and `irq` are all 0.
- R2: `busy` is 1 from the cycle after `rxEnable` is first sampled high. When `rxEnable` is sampled low, `busy` and `cecDriveLow` are 0 from the next cycle, even in the middle of an error pulse.
- R3: Measurement starts only after a start bit: a filtered low of at least 110 ticks that is then released. Before that, falling edges at any spacing raise no fault.
- R4: The minimum period is 67 plus `minTrim`, read as a 3-bit two's-complement value (−4..+3). A measured period below this minimum sets `statMin` (status bit 0).
- R5: The maximum period is 90 plus `maxTrim`, read as a 3-bit two's-complement value. Once a period exceeds this maximum, `statMax` (status bit 1) is set without waiting for the next falling edge.
- R6: A period equal to the trimmed minimum, or equal to the trimmed maximum, raises no fault.
- R7: A short-cycle fault holds `cecDriveLow` high for exactly 119 sampling ticks and then releases it. A long-cycle fault does not drive the line.
- R8: After any fault the block returns to waiting for a start bit. Later falling edges with no new start bit raise no fault.
- R9: Status flags are sticky. A 1 on `clrStatus` bit 0 clears `statMin`, and a 1 on bit 1 clears `statMax`. A fault arriving in the same cycle as the clear wins.
- R10: `irq` is 1 exactly when a set status flag has its bit set in `irqMask` (bit 0 for `statMin`, bit 1 for `statMax`).
- R11: The filter ignores a line change that lasts `filtLen` ticks or fewer. It accepts a change that holds for `filtLen`+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Sampling tick, one clock cycle wide, at least two cycles apart |
| rxEnable | input | 1 | Receiver on |
| cecIn | input | 1 | Raw bus line level |
| filtLen | input | 3 | Glitch filter length in ticks |
| minTrim | input | 3 | Signed trim of the minimum period |
| maxTrim | input | 3 | Signed trim of the maximum period |
| clrStatus | input | 2 | Write-one-to-clear strobe for the status flags |
| irqMask | input | 2 | Interrupt enable for each status flag |
| cecDriveLow | output | 1 | 1 pulls the bus line low |
| busy | output | 1 | Receiver active |
| statMin | output | 1 | Sticky short-cycle fault |
| statMax | output | 1 | Sticky long-cycle fault |
| irq | output | 1 | Error interrupt |

## Verification
A line edge driven by the bench reaches the measuring counter after a fixed delay: two synchronizer flops, then `filtLen`+1 ticks of filtering, then one edge-detect register. Because every edge has the same delay, the periods the bench sets in ticks are exactly the periods the block measures. A long-cycle fault appears one cycle after the counter passes the maximum, and a short-cycle fault and the start of the drive pulse appear one cycle after the filtered edge. The bench therefore reads the status flags several ticks after each stimulus, and it checks the trim sweeps at the exact boundary periods computed from 67 and 90. The drive pulse is timed by counting the sampling ticks during which `cecDriveLow` is high, and the disable and clear responses are sampled on the first falling clock edge after the registering edge.

// File: rtl/cec_period_pkg.sv
package cec_period_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_STLOW,
    ST_WAITD,
    ST_MEAS,
    ST_ERRLO
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic setMin;
    logic setMax;
  } dpCmd_t;

endpackage

// File: rtl/cec_period_front.sv
module cec_period_front #(
  parameter int SyncStages = 2,
  parameter int FiltW      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             lineIn,
  input  logic [FiltW-1:0] filtLen,
  output logic             fallPulse,
  output logic             risePulse
);

  logic [SyncStages-1:0] syncQ;
  logic                  lineSync;
  logic                  lineFilt;
  logic                  linePrev;
  logic [FiltW-1:0]      filtCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SyncStages-2:0], lineIn};
  end

  assign lineSync = syncQ[SyncStages-1];

  // a change is taken once it has differed on filtLen+1 ticks in a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineFilt <= 1'b1;
      filtCnt  <= '0;
    end else if (tickEn) begin
      if (lineSync == lineFilt) begin
        filtCnt <= '0;
      end else if (filtCnt >= filtLen) begin
        lineFilt <= lineSync;
        filtCnt  <= '0;
      end else begin
        filtCnt <= filtCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= 1'b1;
    else       linePrev <= lineFilt;
  end

  assign fallPulse = linePrev & ~lineFilt;
  assign risePulse = ~linePrev & lineFilt;

endmodule

// File: rtl/cec_period_dp.sv
module cec_period_dp
  import cec_period_pkg::*;
#(
  parameter int CntW        = 8,
  parameter int TrimW       = 3,
  parameter int BaseMin     = 67,
  parameter int BaseMax     = 90,
  parameter int StartLowMin = 110,
  parameter int ErrLowTicks = 119
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCmd_t           cmd,
  input  logic [TrimW-1:0] minTrim,
  input  logic [TrimW-1:0] maxTrim,
  input  logic [1:0]       clrStatus,
  input  logic [1:0]       irqMask,
  output logic             shortPeriod,
  output logic             longPeriod,
  output logic             startOk,
  output logic             errDone,
  output logic             statMin,
  output logic             statMax,
  output logic             irq
);

  localparam int LimW = CntW + 2;

  logic [CntW-1:0]        cnt;
  logic signed [LimW-1:0] minLim;
  logic signed [LimW-1:0] maxLim;
  logic signed [LimW-1:0] cntS;

  // one saturating tick counter serves start low, bit period and error pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (cmd.clrCnt)            cnt <= '0;
    else if (tickEn && cnt != '1)   cnt <= cnt + 1'b1;
  end

  always_comb begin
    minLim = LimW'(BaseMin) + {{(LimW-TrimW){minTrim[TrimW-1]}}, minTrim};
    maxLim = LimW'(BaseMax) + {{(LimW-TrimW){maxTrim[TrimW-1]}}, maxTrim};
    cntS   = {2'b00, cnt};
  end

  assign shortPeriod = cntS < minLim;
  assign longPeriod  = cntS > maxLim;
  assign startOk     = cnt >= CntW'(StartLowMin);
  assign errDone     = cnt == CntW'(ErrLowTicks);

  // sticky flags, a new fault wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statMin <= 1'b0;
      statMax <= 1'b0;
    end else begin
      if (cmd.setMin)        statMin <= 1'b1;
      else if (clrStatus[0]) statMin <= 1'b0;
      if (cmd.setMax)        statMax <= 1'b1;
      else if (clrStatus[1]) statMax <= 1'b0;
    end
  end

  assign irq = |({statMax, statMin} & irqMask);

endmodule

// File: rtl/cec_period_ctrl.sv
module cec_period_ctrl
  import cec_period_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEnable,
  input  logic   fallPulse,
  input  logic   risePulse,
  input  logic   shortPeriod,
  input  logic   longPeriod,
  input  logic   startOk,
  input  logic   errDone,
  output dpCmd_t cmd,
  output logic   driveLow,
  output logic   busy
);

  rxState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    if (!rxEnable) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: stateNext = ST_IDLE;
        ST_IDLE: begin
          if (fallPulse) begin
            stateNext  = ST_STLOW;
            cmd.clrCnt = 1'b1;
          end
        end
        ST_STLOW: begin
          if (risePulse) stateNext = startOk ? ST_WAITD : ST_IDLE;
        end
        ST_WAITD: begin
          if (fallPulse) begin
            stateNext  = ST_MEAS;
            cmd.clrCnt = 1'b1;
          end
        end
        ST_MEAS: begin
          if (longPeriod) begin
            stateNext  = ST_IDLE;
            cmd.setMax = 1'b1;
          end else if (fallPulse) begin
            cmd.clrCnt = 1'b1;
            if (shortPeriod) begin
              stateNext  = ST_ERRLO;
              cmd.setMin = 1'b1;
            end
          end
        end
        ST_ERRLO: begin
          if (errDone) stateNext = ST_IDLE;
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  assign driveLow = (state == ST_ERRLO);
  assign busy     = (state != ST_OFF);

endmodule

// File: rtl/cec_period_check.sv
module cec_period_check
  import cec_period_pkg::*;
#(
  parameter int SyncStages  = 2,
  parameter int FiltW       = 3,
  parameter int CntW        = 8,
  parameter int TrimW       = 3,
  parameter int BaseMin     = 67,
  parameter int BaseMax     = 90,
  parameter int StartLowMin = 110,
  parameter int ErrLowTicks = 119
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             rxEnable,
  input  logic             cecIn,
  input  logic [FiltW-1:0] filtLen,
  input  logic [TrimW-1:0] minTrim,
  input  logic [TrimW-1:0] maxTrim,
  input  logic [1:0]       clrStatus,
  input  logic [1:0]       irqMask,
  output logic             cecDriveLow,
  output logic             busy,
  output logic             statMin,
  output logic             statMax,
  output logic             irq
);

  dpCmd_t cmd;
  logic   fallPulse, risePulse;
  logic   shortPeriod, longPeriod, startOk, errDone;

  cec_period_front #(.SyncStages(SyncStages), .FiltW(FiltW)) uFront (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineIn(cecIn),
    .filtLen(filtLen), .fallPulse(fallPulse), .risePulse(risePulse)
  );

  cec_period_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable),
    .fallPulse(fallPulse), .risePulse(risePulse),
    .shortPeriod(shortPeriod), .longPeriod(longPeriod),
    .startOk(startOk), .errDone(errDone),
    .cmd(cmd), .driveLow(cecDriveLow), .busy(busy)
  );

  cec_period_dp #(
    .CntW(CntW), .TrimW(TrimW), .BaseMin(BaseMin), .BaseMax(BaseMax),
    .StartLowMin(StartLowMin), .ErrLowTicks(ErrLowTicks)
  ) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd),
    .minTrim(minTrim), .maxTrim(maxTrim),
    .clrStatus(clrStatus), .irqMask(irqMask),
    .shortPeriod(shortPeriod), .longPeriod(longPeriod),
    .startOk(startOk), .errDone(errDone),
    .statMin(statMin), .statMax(statMax), .irq(irq)
  );

endmodule

// File: rtl/cec_period_check_sva.sv
module cec_period_check_sva (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic [1:0] clrStatus,
  input logic       cecDriveLow,
  input logic       busy,
  input logic       statMin,
  input logic       statMax
);

  // R2: a low enable stops the receiver and frees the line on the next cycle
  a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!busy && !cecDriveLow));

  // R2: the line is only driven while the receiver is active
  a_r2_drive_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    cecDriveLow |-> busy);

  // R7: the error pulse begins together with a short-cycle flag
  a_r7_pulse_flags_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cecDriveLow) |-> statMin);

  // R9: flags hold until their clear bit is written
  a_r9_min_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statMin && !clrStatus[0]) |=> statMin);

  a_r9_max_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statMax && !clrStatus[1]) |=> statMax);

  // R4 / R5: one measured period yields at most one kind of fault
  a_r5_one_fault: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(statMin) && $rose(statMax)));

endmodule

bind cec_period_check cec_period_check_sva uChk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clrStatus(clrStatus),
  .cecDriveLow(cecDriveLow), .busy(busy), .statMin(statMin), .statMax(statMax)
);

// File: tb/cec_period_check_test.sv
module cec_period_check_test;

  localparam int ClkPeriod = 10;
  localparam int TickDiv   = 4;
  localparam int BitLow    = 24;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       rxEnable = 1'b0;
  logic       busDrive = 1'b1;
  logic [2:0] filtLen = 3'd2;
  logic [2:0] minTrim = 3'd0;
  logic [2:0] maxTrim = 3'd0;
  logic [1:0] clrStatus = 2'b00;
  logic [1:0] irqMask = 2'b11;
  logic       cecDriveLow, busy, statMin, statMax, irq;
  logic       cecIn;

  int checks = 0;
  int fails = 0;
  int tickCount = 0;
  int lowTicks = 0;
  int divCnt = 0;

  assign cecIn = busDrive & ~cecDriveLow;

  cec_period_check uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxEnable(rxEnable),
    .cecIn(cecIn), .filtLen(filtLen), .minTrim(minTrim), .maxTrim(maxTrim),
    .clrStatus(clrStatus), .irqMask(irqMask), .cecDriveLow(cecDriveLow),
    .busy(busy), .statMin(statMin), .statMax(statMax), .irq(irq)
  );

  always #(ClkPeriod/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt <= (divCnt == TickDiv-1) ? 0 : divCnt + 1;
    tickEn <= (divCnt == TickDiv-1);
  end

  always @(posedge clk) begin
    if (tickEn) tickCount <= tickCount + 1;
    if (tickEn && cecDriveLow) lowTicks <= lowTicks + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    int target;
    target = tickCount + n;
    while (tickCount < target) @(negedge clk);
  endtask

  task automatic sendStart(input int lowLen);
    busDrive = 1'b0;
    waitTicks(lowLen);
    busDrive = 1'b1;
    waitTicks(27);
  endtask

  task automatic sendFall();
    busDrive = 1'b0;
    waitTicks(BitLow);
    busDrive = 1'b1;
  endtask

  task automatic clearAll();
    @(negedge clk);
    clrStatus = 2'b11;
    @(negedge clk);
    clrStatus = 2'b00;
    @(negedge clk);
  endtask

  // start bit, reference fall, second fall period ticks later
  task automatic runPeriod(input int period);
    lowTicks = 0;
    sendStart(121);
    sendFall();
    waitTicks(period - BitLow);
    sendFall();
  endtask

  int minLim, maxLim;

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 drive", int'(cecDriveLow), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 status", int'({statMax, statMin, irq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    rxEnable = 1'b1;
    @(negedge clk);
    check("R2 busy after enable", int'(busy), 1);
    waitTicks(5);

    // R4 / R6 / R7: minimum trim sweep at the boundary
    for (int t = -4; t <= 3; t++) begin
      minTrim = 3'(t);
      minLim  = 67 + t;
      runPeriod(minLim - 1);
      waitTicks(130);
      check("R4 short sets statMin", int'(statMin), 1);
      check("R7 pulse length", lowTicks, 119);
      check("R4 no long fault", int'(statMax), 0);
      clearAll();
      runPeriod(minLim);
      waitTicks(4);
      check("R6 min boundary ok", int'({statMax, statMin}), 0);
      check("R7 no pulse in range", lowTicks, 0);
      waitTicks(130);
      clearAll();
    end
    minTrim = 3'd0;

    // R5 / R6: maximum trim sweep at the boundary
    for (int t = -4; t <= 3; t++) begin
      maxTrim = 3'(t);
      maxLim  = 90 + t;
      runPeriod(maxLim);
      check("R6 max boundary ok", int'({statMax, statMin}), 0);
      waitTicks(130);
      clearAll();
      runPeriod(maxLim + 1);
      check("R5 long sets statMax", int'(statMax), 1);
      check("R7 long does not drive", lowTicks, 0);
      check("R5 no short fault", int'(statMin), 0);
      // R8: no start bit, so close falls are ignored
      clearAll();
      sendFall();
      waitTicks(30 - BitLow);
      sendFall();
      waitTicks(4);
      check("R8 hunts for start", int'({statMax, statMin}), 0);
    end
    maxTrim = 3'd0;

    // R3: a start low that is too short does not arm measurement
    lowTicks = 0;
    sendStart(50);
    sendFall();
    waitTicks(30 - BitLow);
    sendFall();
    waitTicks(150);
    check("R3 no start no fault", int'({statMax, statMin}), 0);
    check("R3 no pulse", lowTicks, 0);

    // R11: a glitch of filtLen ticks is ignored, filtLen+1 is taken
    sendStart(121);
    sendFall();
    waitTicks(30 - BitLow);
    busDrive = 1'b0;
    waitTicks(2);
    busDrive = 1'b1;
    waitTicks(80 - 32);
    sendFall();
    check("R11 short glitch ignored", int'({statMax, statMin}), 0);
    waitTicks(130);
    clearAll();
    lowTicks = 0;
    sendStart(121);
    sendFall();
    waitTicks(30 - BitLow);
    busDrive = 1'b0;
    waitTicks(3);
    busDrive = 1'b1;
    waitTicks(10);
    check("R11 long glitch taken", int'(statMin), 1);

    // R10 masking, R9 per-bit clear
    waitTicks(130);
    irqMask = 2'b00;
    @(negedge clk);
    check("R10 masked irq", int'(irq), 0);
    irqMask = 2'b10;
    @(negedge clk);
    check("R10 other bit masked", int'(irq), 0);
    irqMask = 2'b01;
    @(negedge clk);
    check("R10 enabled irq", int'(irq), 1);
    clrStatus = 2'b10;
    @(negedge clk);
    clrStatus = 2'b00;
    check("R9 wrong bit keeps", int'(statMin), 1);
    clrStatus = 2'b01;
    @(negedge clk);
    clrStatus = 2'b00;
    check("R9 clear bit0", int'(statMin), 0);
    check("R10 irq drops", int'(irq), 0);
    irqMask = 2'b11;

    // R2: disable in the middle of the error pulse
    runPeriod(40);
    waitTicks(10);
    check("R2 pulse active", int'(cecDriveLow), 1);
    rxEnable = 1'b0;
    @(negedge clk);
    check("R2 drive released", int'(cecDriveLow), 0);
    check("R2 busy dropped", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule